// File: doc/BRIEF.md
# Polling Host Controller for an SPI-Attached UART

This block is the host side of a serial port whose UART lives in a separate device on an SPI bus. Every device access is one 16-bit full-duplex exchange. The block builds those exchanges itself and presents a plain byte-stream interface to the rest of the chip. The transmit side and the receive side each use a valid/ready handshake.

After reset the block programs the device's baud divisor from a rate selector. It reads the configuration back to confirm it and retries at a fixed interval if the read-back differs. It then reports whether the handshake succeeded. To send a byte, it polls the device until the device's transmit holding register has room, then writes the byte. A line feed is always sent as a carriage return followed by the line feed.

Received bytes are gathered into a small local circular buffer. This happens in two ways. When the buffer is empty and the consumer wants a byte, the block drains the device. It also keeps any byte the device returns alongside a transmit write.

Top module: `spi_uart_host`

## Requirements
- R1: Outside an exchange `spi_cs_n` and `spi_sclk` are both 1. An exchange begins with `spi_cs_n` and `spi_sclk` going to 0 together. It then moves 16 bits MSB first: `spi_mosi` changes only while `spi_sclk` is 0 and stays stable while it is 1, and `spi_miso` is taken at the end of each high phase. The exchange finishes with `spi_sclk` and `spi_cs_n` returning to 1 after the sixteenth bit.
- R2: Bits 15:14 of each outgoing word select the operation: 11 writes the configuration (baud code in bits 3:0, bits 13:4 zero), 01 reads the configuration, 10 writes a data byte (bits 7:0), and 00 reads data (all other bits zero). In every response, bit 15 flags a received byte (held in bits 7:0) and bit 14 flags transmit space. In a configuration read, bits 13:0 carry the stored configuration.
- R3: `rate_sel` values 0 to 8 stand for 1200, 2400, 4800, 9600, 19200, 38400, 57600, 115200 and 230400 baud. They map to baud codes 14, 13, 12, 11, 10, 9, 2, 1 and 0 respectively. Every other value uses code 1.
- R4: After reset the block writes the configuration, reads it back and compares bits 13:0 of the response with the word it wrote. On a match it sets `init_done` with `init_fail` at 0, and `init_done` then stays set until the next reset.
- R5: On a mismatch the block waits `RETRY_GAP` cycles and repeats the write and read, for at most `RETRY_MAX` attempts. If the last attempt also mismatches, it sets both `init_done` and `init_fail` and then operates normally.
- R6: `tx_ready` is 1 only after initialisation and while no transfer is under way. Once a byte is accepted, the block repeats configuration reads until a response has bit 14 set, and only then issues the data write.
- R7: An accepted byte 0x0A is sent as 0x0D followed by 0x0A, and each of the two bytes is preceded by its own polling. Any other byte is sent once.
- R8: While idle, with the local buffer empty, `tx_valid` low and `rx_ready` high, the block starts issuing data reads. It stores the byte from each response that has bit 15 set. It stops at the first response with bit 15 clear, or when the buffer holds 16 bytes.
- R9: If the response to a data write has bit 15 set, its byte is stored when the buffer has room and dropped when the buffer is full.
- R10: The buffer holds 16 bytes and delivers them in arrival order. `rx_valid` is 1 whenever the buffer is not empty, `rx_data` shows the oldest byte, and a byte is removed on each cycle in which `rx_valid` and `rx_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 4 | Requested line rate index, sampled when the configuration is written |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Block idle and able to accept a transmit byte |
| rx_data | output | 8 | Oldest buffered received byte |
| rx_valid | output | 1 | Local buffer not empty |
| rx_ready | input | 1 | Consumer takes a byte; with an empty buffer, requests a drain |
| init_done | output | 1 | Configuration handshake finished |
| init_fail | output | 1 | Handshake finished without a matching read-back |
| spi_cs_n | output | 1 | Device select, active low |
| spi_sclk | output | 1 | Serial clock, high when idle |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The assertions assume three things about the environment. `rst_n` is held low before the first clock edge. `spi_miso` holds its value for the whole high phase of `spi_sclk`. The consumer and producer change `tx_valid`, `tx_data` and `rx_ready` only away from the rising clock edge. The bench device model sets `spi_miso` only just after a falling serial-clock edge or at the start of a select. All handshake inputs are driven on the falling system-clock edge, so the block samples settled values. The device model inserts random transmit-busy stretches and random incoming bytes. This exercises the polling and both capture paths while keeping the buffer below full, except in the directed case that fills it on purpose.

// File: rtl/spi_uart_host.sv
`timescale 1ns/1ps
module spi_uart_host #(
  parameter int CLK_DIV   = 100,
  parameter int RETRY_GAP = 10000,
  parameter int RETRY_MAX = 100,
  parameter int BUF_AW    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rate_sel,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       init_done,
  output logic       init_fail,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  localparam int DEPTH = 1 << BUF_AW;
  localparam int CW    = BUF_AW + 1;
  localparam int DW    = $clog2(CLK_DIV + 1);
  localparam int GW    = $clog2(RETRY_GAP + 1);
  localparam int TW    = $clog2(RETRY_MAX + 1);

  typedef enum logic [2:0] {
    ST_CFGW, ST_CFGR, ST_GAP, ST_IDLE, ST_POLL, ST_SEND, ST_DRAIN
  } state_t;

  function automatic logic [3:0] baud_code(input logic [3:0] s);
    case (s)
      4'd0: baud_code = 4'd14;
      4'd1: baud_code = 4'd13;
      4'd2: baud_code = 4'd12;
      4'd3: baud_code = 4'd11;
      4'd4: baud_code = 4'd10;
      4'd5: baud_code = 4'd9;
      4'd6: baud_code = 4'd2;
      4'd8: baud_code = 4'd0;
      default: baud_code = 4'd1;
    endcase
  endfunction

  state_t          state;
  logic [3:0]      code_q;
  logic [TW-1:0]   tries;
  logic [GW-1:0]   gap;
  logic [7:0]      txb;
  logic            need_cr;

  logic            xbusy, xdone, xgo;
  logic [15:0]     xsh, xword;
  logic [4:0]      xbit;
  logic [DW-1:0]   xdiv;
  wire             xtick = (xdiv == DW'(CLK_DIV - 1));

  logic [7:0]      mem [DEPTH];
  logic [BUF_AW-1:0] wp, rp;
  logic [CW-1:0]   cnt, cnt_nxt;
  logic            push, pop;

  wire in_exch = (state == ST_CFGW) || (state == ST_CFGR) || (state == ST_POLL) ||
                 (state == ST_SEND) || (state == ST_DRAIN);

  assign xgo      = in_exch && !xbusy && !xdone;
  assign spi_mosi = xsh[15];
  assign tx_ready = (state == ST_IDLE);
  assign rx_valid = (cnt != '0);
  assign rx_data  = mem[rp];
  assign pop      = rx_valid && rx_ready;
  assign push     = xdone && xsh[15] && ((state == ST_SEND) || (state == ST_DRAIN)) &&
                    (cnt != CW'(DEPTH));
  assign cnt_nxt  = cnt + CW'(push) - CW'(pop);

  always_comb begin
    case (state)
      ST_CFGW: xword = {2'b11, 10'd0, baud_code(rate_sel)};
      ST_CFGR,
      ST_POLL: xword = {2'b01, 14'd0};
      ST_SEND: xword = {2'b10, 6'd0, need_cr ? 8'h0D : txb};
      default: xword = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xbusy    <= 1'b0;
      xdone    <= 1'b0;
      xsh      <= '0;
      xbit     <= '0;
      xdiv     <= '0;
      spi_cs_n <= 1'b1;
      spi_sclk <= 1'b1;
    end else begin
      xdone <= 1'b0;
      if (xgo) begin
        xbusy    <= 1'b1;
        spi_cs_n <= 1'b0;
        spi_sclk <= 1'b0;
        xsh      <= xword;
        xbit     <= '0;
        xdiv     <= '0;
      end else if (xbusy) begin
        xdiv <= xtick ? '0 : xdiv + 1'b1;
        if (xtick) begin
          if (spi_cs_n) begin
            xbusy <= 1'b0;
            xdone <= 1'b1;
          end else if (!spi_sclk) begin
            spi_sclk <= 1'b1;
            spi_cs_n <= (xbit == 5'd16);
          end else begin
            xsh      <= {xsh[14:0], spi_miso};
            xbit     <= xbit + 1'b1;
            spi_sclk <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= xsh[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CFGW;
      code_q    <= '0;
      tries     <= '0;
      gap       <= '0;
      txb       <= '0;
      need_cr   <= 1'b0;
      init_done <= 1'b0;
      init_fail <= 1'b0;
    end else begin
      case (state)
        ST_CFGW: begin
          if (xgo) code_q <= baud_code(rate_sel);
          if (xdone) state <= ST_CFGR;
        end
        ST_CFGR: if (xdone) begin
          if (xsh[13:0] == {10'd0, code_q}) begin
            init_done <= 1'b1;
            state     <= ST_IDLE;
          end else if (tries == TW'(RETRY_MAX - 1)) begin
            init_done <= 1'b1;
            init_fail <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            tries <= tries + 1'b1;
            gap   <= '0;
            state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap == GW'(RETRY_GAP - 1)) state <= ST_CFGW;
          else gap <= gap + 1'b1;
        end
        ST_IDLE: begin
          if (tx_valid) begin
            txb     <= tx_data;
            need_cr <= (tx_data == 8'h0A);
            state   <= ST_POLL;
          end else if (rx_ready && cnt == '0) begin
            state <= ST_DRAIN;
          end
        end
        ST_POLL: if (xdone && xsh[14]) state <= ST_SEND;
        ST_SEND: if (xdone) begin
          if (need_cr) begin
            need_cr <= 1'b0;
            state   <= ST_POLL;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_DRAIN: if (xdone) begin
          if (!xsh[15] || cnt_nxt == CW'(DEPTH)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r1_idle_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  a_r1_select_with_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> !spi_sclk);

  a_r1_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sclk && $past(!spi_cs_n && spi_sclk)) |-> $stable(spi_mosi));

  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r5_fail_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_fail |-> init_done);

  a_r6_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> init_done);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt)));

endmodule

// File: tb/spi_uart_host_bench.sv
`timescale 1ns/1ps
module spi_uart_host_bench;
  localparam int CDIV  = 2;
  localparam int GAPC  = 20;
  localparam int TRIES = 4;
  localparam int WD    = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] rate_sel;
  logic [7:0] tx_data, rx_data;
  logic tx_valid, tx_ready, rx_valid, rx_ready, init_done, init_fail;
  logic spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  spi_uart_host #(.CLK_DIV(CDIV), .RETRY_GAP(GAPC), .RETRY_MAX(TRIES), .BUF_AW(4)) u_spi_uart_host (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .init_done(init_done), .init_fail(init_fail),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int ntests = 0, nfail = 0;

  // device model state
  logic [13:0] s_cfg = 14'h3FFF;
  bit   s_corrupt = 0, s_busy_rand = 0;
  int   s_busy = 0;
  logic [7:0] q [0:511];
  int   qh = 0, qt = 0;
  logic [7:0] gave [0:511];
  int   ng = 0;
  logic [7:0] sent [0:511];
  int   nsent = 0;
  int   n_cfgw = 0, n_rdcfg = 0, n_rddata = 0, frame_err = 0, busy_sends = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1, mosi_cap = 1'b0, miso_r = 1'b0;
  int   bitn = 0;
  logic [15:0] cmd = '0, resp = '0;
  assign spi_miso = miso_r;

  always @(negedge clk) begin
    if (prev_cs && !spi_cs_n) begin
      if (spi_sclk) frame_err++;
      bitn = 0;
      cmd  = '0;
      resp = {(qh != qt), (s_busy == 0), 14'd0};
      miso_r = resp[15];
    end else if (!spi_cs_n) begin
      if (!prev_sclk && spi_sclk) begin
        cmd = {cmd[14:0], spi_mosi};
        mosi_cap = spi_mosi;
        bitn++;
      end else if (prev_sclk && spi_sclk) begin
        if (spi_mosi !== mosi_cap) frame_err++;
      end else if (prev_sclk && !spi_sclk) begin
        if (bitn == 2) resp[13:0] = (cmd[1:0] == 2'b01) ? s_cfg : {6'd0, q[qh]};
        if (bitn < 16) miso_r = resp[15-bitn];
      end
    end else if (!prev_cs && spi_cs_n) begin
      if (!spi_sclk || bitn != 16) frame_err++;
      case (cmd[15:14])
        2'b11: begin n_cfgw++; s_cfg = cmd[13:0] ^ {13'd0, s_corrupt}; end
        2'b01: begin n_rdcfg++; if (s_busy > 0) s_busy--; end
        2'b10: begin
          if (!resp[14]) busy_sends++;
          sent[nsent] = cmd[7:0]; nsent++;
          s_busy = s_busy_rand ? int'($urandom_range(0, 3)) : 0;
          if (resp[15]) begin gave[ng] = q[qh]; ng++; qh++; end
        end
        default: begin
          n_rddata++;
          if (resp[15]) begin gave[ng] = q[qh]; ng++; qh++; end
        end
      endcase
    end
    prev_cs = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  // receive monitor for the random phase
  bit mon_en = 0;
  int mon_start = 0, mon_cnt = 0, mon_bad = 0;
  logic [7:0] mon_act = '0, mon_exp = '0;
  always @(negedge clk) begin
    if (mon_en && rx_valid && rx_ready) begin
      if (rx_data !== gave[mon_start + mon_cnt] && mon_bad == 0) begin
        mon_act = rx_data;
        mon_exp = gave[mon_start + mon_cnt];
        mon_bad++;
      end
      mon_cnt++;
    end
  end

  initial begin
    repeat (WD) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", ntests + 1, nfail + 1);
    $finish;
  end

  logic [7:0] exp_tx [0:511];
  int nexp = 0;

  function automatic logic [3:0] exp_code(input int s);
    case (s)
      0: exp_code = 4'd14;  1: exp_code = 4'd13;  2: exp_code = 4'd12;
      3: exp_code = 4'd11;  4: exp_code = 4'd10;  5: exp_code = 4'd9;
      6: exp_code = 4'd2;   8: exp_code = 4'd0;
      default: exp_code = 4'd1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] sel);
    @(negedge clk);
    rst_n = 1'b0;
    rate_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_init();
    for (int t = 0; t < 20000 && !init_done; t++) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    for (int t = 0; t < 20000 && !tx_ready; t++) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    if (b == 8'h0A) begin exp_tx[nexp] = 8'h0D; nexp++; end
    exp_tx[nexp] = b; nexp++;
    tx_data = b;
    tx_valid = 1'b1;
    for (int t = 0; t < 20000 && !tx_ready; t++) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] b);
    rx_ready = 1'b1;
    for (int t = 0; t < 20000 && !rx_valid; t++) @(negedge clk);
    b = rx_data;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic pulse_request();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    int base, base2, bad;
    logic [7:0] b;
    void'($urandom(32'h0000_5eed));
    rate_sel = 4'd7; tx_data = '0; tx_valid = 1'b0; rx_ready = 1'b0;

    repeat (2) @(negedge clk);
    chk(spi_cs_n && spi_sclk, "R1 idle lines in reset", {spi_cs_n, spi_sclk}, 2'b11);
    chk(!rx_valid, "R10 buffer empty in reset", rx_valid, 0);
    chk(!tx_ready && !init_done, "R6 not ready in reset", {tx_ready, init_done}, 0);
    base = n_cfgw;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_ready, "R6 not ready during init", tx_ready, 0);
    wait_init();
    chk(init_done && !init_fail, "R4 init result", {init_done, init_fail}, 2'b10);
    chk(s_cfg == 14'd1, "R3 default rate code", s_cfg, 1);
    chk(n_cfgw - base == 1, "R4 single config write", n_cfgw - base, 1);

    for (int s = 0; s < 16; s++) begin
      base = n_cfgw;
      do_reset(4'(s));
      wait_init();
      chk(s_cfg == {10'd0, exp_code(s)}, "R3 baud code", s_cfg, exp_code(s));
      chk(n_cfgw - base == 1 && !init_fail, "R4 match on first try", n_cfgw - base, 1);
    end

    s_corrupt = 1;
    base = n_cfgw;
    do_reset(4'd3);
    wait_init();
    chk(init_done && init_fail, "R5 fail flags", {init_done, init_fail}, 2'b11);
    chk(n_cfgw - base == TRIES, "R5 attempt count", n_cfgw - base, TRIES);
    send(8'h41);
    wait_idle();
    chk(sent[nsent-1] == 8'h41, "R5 operates after failure", sent[nsent-1], 8'h41);
    s_corrupt = 0;
    do_reset(4'd7);
    wait_init();
    chk(!init_fail, "R5 clean init after fix", init_fail, 0);

    s_busy_rand = 1;
    base = n_rdcfg;
    send(8'h55); wait_idle();
    send(8'h66); wait_idle();
    chk(busy_sends == 0, "R6 write only with space", busy_sends, 0);
    chk(n_rdcfg - base >= 2, "R6 poll before write", n_rdcfg - base, 2);
    base = nsent;
    send(8'h0A); wait_idle();
    chk(nsent - base == 2 && sent[base] == 8'h0D && sent[base+1] == 8'h0A,
        "R7 line feed expansion", {sent[base], sent[base+1]}, 16'h0D0A);
    base = nsent;
    send(8'h0D); wait_idle();
    chk(nsent - base == 1 && sent[base] == 8'h0D, "R7 plain byte once", nsent - base, 1);
    s_busy_rand = 0;

    q[qt] = 8'h11; qt++; q[qt] = 8'h22; qt++; q[qt] = 8'h33; qt++;
    base = n_rddata;
    pulse_request();
    wait_idle();
    chk(n_rddata - base == 4, "R8 drain stops on empty flag", n_rddata - base, 4);
    for (int i = 0; i < 3; i++) begin
      get_byte(b);
      chk(b == 8'(8'h11 * (i + 1)), "R10 drained order", b, 8'h11 * (i + 1));
    end

    for (int i = 0; i < 20; i++) begin q[qt] = 8'(8'h80 + i); qt++; end
    wait_idle();
    pulse_request();
    wait_idle();
    chk(qt - qh == 4, "R8 drain stops when full", qt - qh, 4);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      get_byte(b);
      if (b != 8'(8'h80 + i)) bad++;
    end
    chk(bad == 0, "R10 order across refill", bad, 0);

    wait_idle();
    for (int i = 0; i < 18; i++) begin q[qt] = 8'(8'hC0 + i); qt++; end
    for (int i = 0; i < 18; i++) send(8'(8'h30 + i));
    wait_idle();
    chk(qh == qt, "R9 every write consumed a byte", qt - qh, 0);
    chk(rx_valid, "R9 bytes kept from writes", rx_valid, 1);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      get_byte(b);
      if (b != 8'(8'hC0 + i)) bad++;
    end
    chk(bad == 0, "R9 first sixteen kept", bad, 0);
    q[qt] = 8'h5A; qt++;
    get_byte(b);
    chk(b == 8'h5A, "R9 overflow bytes dropped", b, 8'h5A);

    wait_idle();
    s_busy_rand = 1;
    mon_start = ng;
    mon_en = 1;
    rx_ready = 1'b1;
    base2 = nsent;
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 1) == 1) begin q[qt] = 8'($urandom); qt++; end
      if ($urandom_range(0, 5) == 0) send(8'h0A);
      else send(8'($urandom));
    end
    for (int t = 0; t < 20000 && !(qh == qt && tx_ready && !rx_valid && nsent == nexp); t++)
      @(negedge clk);
    repeat (200) @(negedge clk);
    chk(mon_bad == 0, "R10 random receive order", mon_act, mon_exp);
    chk(mon_cnt == ng - mon_start, "R8 all device bytes delivered", mon_cnt, ng - mon_start);
    mon_en = 0;
    rx_ready = 1'b0;

    bad = 0;
    for (int i = 0; i < nexp && i < nsent; i++) if (sent[i] != exp_tx[i]) bad++;
    chk(nsent == nexp, "R2 R7 byte count on the wire", nsent, nexp);
    chk(bad == 0, "R2 R7 transmitted stream", bad, 0);
    chk(nsent - base2 >= 60, "R6 random sends completed", nsent - base2, 60);
    chk(busy_sends == 0, "R6 no write while busy", busy_sends, 0);
    chk(frame_err == 0, "R1 exchange framing", frame_err, 0);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule